// File: doc/BRIEF.md
# Predicate-Define Compare Unit

This block carries out predicate-setting compare operations. Each operation compares two 64-bit source operands under a compare opcode. It then updates two destinations in a one-bit predicate register file. Every destination carries its own update type, and that type decides how the compare result and a qualifying predicate combine into the value stored.

The qualifying predicate is read from the same register file in the cycle the operation is presented. The unit applies the rule for each destination type:

- Plain types (direct and inverted) always write the register. They write zero when the qualifier is false.
- Accumulating types (OR and inverted-OR) only ever set a register to one. They leave it untouched when the qualifier is false or the condition does not hold.

A separate read port lets the surrounding pipeline observe any predicate. Entry 0 is a constant true.

Top module: `pdef_unit`

## Requirements
- R1: The compare opcode `op_cmp` selects the condition: 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than, 4 signed less-or-equal. Codes 5 to 7 yield a false result.
- R2: With a true qualifier, a destination of type 0 (direct) receives the compare result, and a destination of type 1 (inverted) receives its inverse.
- R3: With a true qualifier, a type 2 (OR) destination is set to 1 when the result is true and otherwise keeps its value. A type 3 (inverted OR) destination is set to 1 when the result is false and otherwise keeps its value.
- R4: With a false qualifier, type 0 and type 1 destinations are cleared to 0 whatever the comparison gives.
- R5: With a false qualifier, type 2 and type 3 destinations keep their value.
- R6: Entry 0 always reads 1, and writes aimed at it are dropped.
- R7: When both destinations name the same register, the write from destination 1 is the one that lands.
- R8: An update presented with `op_valid` high is visible on `rd_val` from the clock edge that accepts it onward, and not before that edge. With `op_valid` low the register file does not change.
- R9: After reset every entry other than 0 reads 0.
- R10: The qualifier is the current content of the register named by `qp_idx`, so index 0 makes the operation unconditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_cmp | input | 3 | Compare opcode |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| qp_idx | input | 6 | Index of the qualifying predicate |
| dst0_idx | input | 6 | Index of destination 0 |
| dst0_type | input | 2 | Update type of destination 0 |
| dst1_idx | input | 6 | Index of destination 1 |
| dst1_type | input | 2 | Update type of destination 1 |
| rd_idx | input | 6 | Observation read index |
| rd_val | output | 1 | Predicate value at `rd_idx` |

## Verification
Every predicate update is due exactly one clock edge after the operation is presented. The read port is combinational from the stored bits, so a result shows on `rd_val` straight after the accepting edge. The bench presents each operation on a falling edge and holds it through one rising edge. It then reads back in the low phase that follows, and one directed test also reads the old value before that rising edge to confirm nothing appears early. The qualifier is sampled in the same cycle as the operation, so a predicate written by one operation qualifies the very next one.

// File: rtl/pdef_pkg.sv
package pdef_pkg;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_LT  = 3'd2,
        CMP_LTU = 3'd3,
        CMP_LE  = 3'd4
    } cmp_op_e;

    typedef enum logic [1:0] {
        PT_DIR  = 2'd0,
        PT_INV  = 2'd1,
        PT_OR   = 2'd2,
        PT_ORN  = 2'd3
    } pred_type_e;

    localparam int NUM_DST = 2;

endpackage

// File: rtl/pdef_cmp.sv
module pdef_cmp #(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              res_o
);
    import pdef_pkg::*;

    always_comb begin
        case (op_i)
            CMP_EQ:  res_o = (a_i == b_i);
            CMP_NE:  res_o = (a_i != b_i);
            CMP_LT:  res_o = ($signed(a_i) <  $signed(b_i));
            CMP_LTU: res_o = (a_i < b_i);
            CMP_LE:  res_o = ($signed(a_i) <= $signed(b_i));
            default: res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdef_rule.sv
module pdef_rule (
    input  logic       qual_i,
    input  logic       res_i,
    input  logic [1:0] type_i,
    output logic       we_o,
    output logic       wval_o
);
    import pdef_pkg::*;

    always_comb begin
        case (type_i)
            PT_DIR: begin
                we_o   = 1'b1;
                wval_o = qual_i & res_i;
            end
            PT_INV: begin
                we_o   = 1'b1;
                wval_o = qual_i & ~res_i;
            end
            PT_OR: begin
                we_o   = qual_i & res_i;
                wval_o = 1'b1;
            end
            default: begin
                we_o   = qual_i & ~res_i;
                wval_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pdef_prf.sv
module pdef_prf #(
    parameter int NUM_PRED = 64,
    parameter int NUM_WR   = 2,
    localparam int IDX_W   = $clog2(NUM_PRED)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             qp_idx_i,
    output logic                         qp_val_o,
    input  logic [IDX_W-1:0]             rd_idx_i,
    output logic                         rd_val_o,
    input  logic [NUM_WR-1:0]            we_i,
    input  logic [NUM_WR-1:0][IDX_W-1:0] widx_i,
    input  logic [NUM_WR-1:0]            wval_i,
    output logic [NUM_PRED-1:0]          bits_o
);

    typedef struct packed {
        logic [NUM_PRED-1:0] bits;
    } prf_state_t;

    prf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // later ports overwrite earlier ones
        for (int w = 0; w < NUM_WR; w++) begin
            if (we_i[w] && (widx_i[w] != '0)) begin
                st_d.bits[widx_i[w]] = wval_i[w];
            end
        end
        st_d.bits[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qp_val_o = (qp_idx_i == '0) ? 1'b1 : st_q.bits[qp_idx_i];
    assign rd_val_o = (rd_idx_i == '0) ? 1'b1 : st_q.bits[rd_idx_i];
    assign bits_o   = st_q.bits;

endmodule

// File: rtl/pdef_unit.sv
module pdef_unit #(
    parameter int DATA_W   = 64,
    parameter int NUM_PRED = 64,
    localparam int IDX_W   = $clog2(NUM_PRED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_cmp,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IDX_W-1:0]  qp_idx,
    input  logic [IDX_W-1:0]  dst0_idx,
    input  logic [1:0]        dst0_type,
    input  logic [IDX_W-1:0]  dst1_idx,
    input  logic [1:0]        dst1_type,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_val
);
    import pdef_pkg::*;

    logic                          cmp_res;
    logic                          qp_val;
    logic [NUM_DST-1:0][IDX_W-1:0] dst_idx;
    logic [NUM_DST-1:0][1:0]       dst_type;
    logic [NUM_DST-1:0]            dst_we;
    logic [NUM_DST-1:0]            dst_wval;
    logic [NUM_PRED-1:0]           pred_bits;

    assign dst_idx  = {dst1_idx, dst0_idx};
    assign dst_type = {dst1_type, dst0_type};

    pdef_cmp #(.DATA_W(DATA_W)) u_cmp (
        .op_i  (op_cmp),
        .a_i   (src_a),
        .b_i   (src_b),
        .res_o (cmp_res)
    );

    for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
        logic we_raw;
        pdef_rule u_rule (
            .qual_i (qp_val),
            .res_i  (cmp_res),
            .type_i (dst_type[g]),
            .we_o   (we_raw),
            .wval_o (dst_wval[g])
        );
        assign dst_we[g] = we_raw & op_valid;
    end

    pdef_prf #(.NUM_PRED(NUM_PRED), .NUM_WR(NUM_DST)) u_prf (
        .clk      (clk),
        .rst_n    (rst_n),
        .qp_idx_i (qp_idx),
        .qp_val_o (qp_val),
        .rd_idx_i (rd_idx),
        .rd_val_o (rd_val),
        .we_i     (dst_we),
        .widx_i   (dst_idx),
        .wval_i   (dst_wval),
        .bits_o   (pred_bits)
    );

endmodule

// File: rtl/pdef_chk.sv
module pdef_chk #(
    parameter int NUM_PRED = 64,
    localparam int IDX_W   = $clog2(NUM_PRED)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic                qp_val,
    input logic                cmp_res,
    input logic [IDX_W-1:0]    dst0_idx,
    input logic [1:0]          dst0_type,
    input logic [IDX_W-1:0]    dst1_idx,
    input logic [1:0]          dst1_type,
    input logic [IDX_W-1:0]    rd_idx,
    input logic                rd_val,
    input logic [NUM_PRED-1:0] pred_bits
);

    // R6
    zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> rd_val);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(pred_bits));

    // R4
    clear_d0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !qp_val && !dst0_type[1] && dst0_idx != '0 && dst1_idx != dst0_idx)
        |=> !pred_bits[$past(dst0_idx)]);

    // R4
    clear_d1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !qp_val && !dst1_type[1] && dst1_idx != '0)
        |=> !pred_bits[$past(dst1_idx)]);

    // R5
    or_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !qp_val && dst1_type[1] && dst1_idx != '0 && dst0_idx != dst1_idx)
        |=> pred_bits[$past(dst1_idx)] == $past(pred_bits[dst1_idx]));

    // R3
    or_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && qp_val && dst1_type[1] && (cmp_res ^ dst1_type[0]) && dst1_idx != '0)
        |=> pred_bits[$past(dst1_idx)]);

endmodule

bind pdef_unit pdef_chk #(.NUM_PRED(NUM_PRED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .qp_val    (qp_val),
    .cmp_res   (cmp_res),
    .dst0_idx  (dst0_idx),
    .dst0_type (dst0_type),
    .dst1_idx  (dst1_idx),
    .dst1_type (dst1_type),
    .rd_idx    (rd_idx),
    .rd_val    (rd_val),
    .pred_bits (pred_bits)
);

// File: tb/tb_pdef_unit.sv
`timescale 1ns/100ps
module tb_pdef_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_cmp = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [5:0]  qp_idx = '0, dst0_idx = '0, dst1_idx = '0, rd_idx = '0;
    logic [1:0]  dst0_type = '0, dst1_type = '0;
    logic        rd_val;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pdef_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cmp(op_cmp),
        .src_a(src_a), .src_b(src_b), .qp_idx(qp_idx),
        .dst0_idx(dst0_idx), .dst0_type(dst0_type),
        .dst1_idx(dst1_idx), .dst1_type(dst1_type),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
    } vec_t;

    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;

    // R1 vectors: opcode, operands, expected compare result
    localparam vec_t VECS [12] = '{
        '{3'd0, 64'd5, 64'd5, 1'b1},
        '{3'd0, 64'd5, 64'd6, 1'b0},
        '{3'd1, 64'd5, 64'd6, 1'b1},
        '{3'd1, 64'd9, 64'd9, 1'b0},
        '{3'd2, NEG1,  64'd1, 1'b1},
        '{3'd2, 64'd1, NEG1,  1'b0},
        '{3'd3, NEG1,  64'd1, 1'b0},
        '{3'd3, 64'd1, NEG1,  1'b1},
        '{3'd4, 64'd7, 64'd7, 1'b1},
        '{3'd4, 64'd8, 64'd7, 1'b0},
        '{3'd4, MINS,  64'd0, 1'b1},
        '{3'd5, 64'd3, 64'd3, 1'b0}
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int idx, input logic exp, input string tag);
        rd_idx = 6'(idx);
        #0.5;
        chk(tag, rd_val, exp);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input int qp, input int d0, input logic [1:0] t0,
                         input int d1, input logic [1:0] t1);
        @(negedge clk);
        op_cmp = op; src_a = a; src_b = b; qp_idx = 6'(qp);
        dst0_idx = 6'(d0); dst0_type = t0; dst1_idx = 6'(d1); dst1_type = t1;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        for (int i = 1; i < 64; i++) rd_chk(i, 1'b0, "R9 reset clear");
        // R6 constant entry
        rd_chk(0, 1'b1, "R6 entry0 reads 1");

        // R1, R2 table walk: dst0 direct into 10, dst1 inverted into 11
        for (int v = 0; v < 12; v++) begin
            do_op(VECS[v].op, VECS[v].a, VECS[v].b, 0, 10, 2'd0, 11, 2'd1);
            rd_chk(10, VECS[v].exp, "R1 R2 direct result");
            rd_chk(11, ~VECS[v].exp, "R2 inverted result");
        end

        // R6 write to entry 0 dropped
        do_op(3'd0, 64'd1, 64'd2, 0, 0, 2'd0, 0, 2'd1);
        rd_chk(0, 1'b1, "R6 write to 0 ignored");

        // R3 OR accumulate
        do_op(3'd0, 64'd1, 64'd2, 0, 30, 2'd0, 31, 2'd0);   // 30=0, 31=0
        do_op(3'd0, 64'd1, 64'd2, 0, 12, 2'd0, 30, 2'd2);   // OR, false -> keep 0
        rd_chk(30, 1'b0, "R3 OR false keeps 0");
        do_op(3'd0, 64'd4, 64'd4, 0, 12, 2'd0, 30, 2'd2);   // OR, true -> 1
        rd_chk(30, 1'b1, "R3 OR true sets");
        do_op(3'd0, 64'd1, 64'd2, 0, 12, 2'd0, 30, 2'd2);   // OR, false -> keep 1
        rd_chk(30, 1'b1, "R3 OR false keeps 1");
        do_op(3'd0, 64'd4, 64'd4, 0, 31, 2'd3, 12, 2'd0);   // ORN, true -> keep 0
        rd_chk(31, 1'b0, "R3 ORN true keeps 0");
        do_op(3'd0, 64'd1, 64'd2, 0, 31, 2'd3, 12, 2'd0);   // ORN, false -> 1
        rd_chk(31, 1'b1, "R3 ORN false sets");

        // R4 R5 R10 false qualifier from entry 5
        do_op(3'd0, 64'd1, 64'd2, 0, 5, 2'd0, 12, 2'd0);    // p5 = 0
        do_op(3'd0, 64'd1, 64'd1, 0, 40, 2'd0, 42, 2'd2);   // p40=1, p42=1
        do_op(3'd0, 64'd1, 64'd2, 0, 41, 2'd1, 43, 2'd3);   // p41=1, p43=1
        rd_chk(40, 1'b1, "R2 setup p40");
        rd_chk(43, 1'b1, "R3 setup p43");
        do_op(3'd0, 64'd1, 64'd1, 5, 40, 2'd0, 42, 2'd2);
        rd_chk(40, 1'b0, "R4 direct cleared under false qp");
        rd_chk(42, 1'b1, "R5 OR kept under false qp");
        do_op(3'd0, 64'd1, 64'd2, 5, 41, 2'd1, 43, 2'd3);
        rd_chk(41, 1'b0, "R4 inverted cleared under false qp");
        rd_chk(43, 1'b1, "R5 ORN kept under false qp");
        do_op(3'd0, 64'd1, 64'd2, 5, 12, 2'd0, 31, 2'd3);   // p31 would... stays 1
        do_op(3'd0, 64'd1, 64'd2, 0, 44, 2'd0, 12, 2'd0);   // p44 = 0
        do_op(3'd0, 64'd3, 64'd3, 5, 12, 2'd0, 44, 2'd2);   // OR true but qp false
        rd_chk(44, 1'b0, "R5 OR 0 kept under false qp");
        // R10 qualifier true through a written register
        do_op(3'd0, 64'd3, 64'd3, 30, 45, 2'd0, 12, 2'd0);  // p30 is 1
        rd_chk(45, 1'b1, "R10 qp from p30 true");

        // R7 same destination, destination 1 wins
        do_op(3'd0, 64'd7, 64'd7, 0, 20, 2'd0, 20, 2'd1);
        rd_chk(20, 1'b0, "R7 dst1 wins (inverted)");
        do_op(3'd1, 64'd7, 64'd7, 0, 20, 2'd0, 20, 2'd1);
        rd_chk(20, 1'b1, "R7 dst1 wins (inverted of false)");

        // R8 timing and idle
        @(negedge clk);
        op_cmp = 3'd0; src_a = 64'd2; src_b = 64'd2; qp_idx = '0;
        dst0_idx = 6'd50; dst0_type = 2'd0; dst1_idx = 6'd12; dst1_type = 2'd0;
        op_valid = 1'b1;
        rd_chk(50, 1'b0, "R8 not visible before edge");
        @(negedge clk);
        op_valid = 1'b0;
        rd_chk(50, 1'b1, "R8 visible after edge");
        src_b = 64'd9;
        repeat (2) @(negedge clk);
        rd_chk(50, 1'b1, "R8 idle no change");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule